// File: doc/BRIEF.md
# Charge-Unit Interrupt Controller

This block is the digital core of a battery charge counter. An analog integrator outside the block reverses its ramp each time a small fixed amount of charge has passed; every reversal reaches the block as a one-cycle event, together with a direction bit that says whether the current flows into or out of the battery. The block divides these events with a bidirectional prescale counter. Each time the counter wraps in either direction, the block pulls its interrupt output low and latches the sign of that charge unit on its polarity output.

Software answers the interrupt by holding the clear input low for a qualified minimum time. The counter keeps running underneath, so no reversal is lost while the interrupt waits or while clear is low. An auto-clear mode stands in for the interrupt wired back to the clear input: the interrupt is released by itself after a short minimum low time. Shutdown or an undervoltage indication resets everything and releases both outputs, which the block reports through an output-enable signal. Counting starts again only after a settling interval.

The controller is a five-state machine. OFF: held in shutdown or undervoltage. INIT: the settling interval is running. IDLE: counting, interrupt released. LATCH: interrupt low, waiting for a qualified clear. HOLD: interrupt low for the auto-clear minimum. The transitions are OFF→INIT when shutdown and undervoltage are both gone; INIT→IDLE when the settling timer expires; IDLE→LATCH on a wrap with auto-clear off; IDLE→HOLD on a wrap with auto-clear on; LATCH→IDLE on a qualified clear with no wrap in the same cycle; LATCH→LATCH (re-latch) on a qualified clear that meets a wrap; HOLD→IDLE when the hold timer expires; any state→OFF on shutdown or undervoltage.

Top module: `charge_unit_irq`

## Requirements
- R1: A reversal event (rev_evt high at a rising clock edge while the block is counting) increments the prescale counter when rev_chg=1 and decrements it when rev_chg=0. The counter has 2^CNT_W states (1024 by default) and starts at 0. An overflow is an increment from all ones. An underflow is a decrement from zero.
- R2: At the clock edge that takes an overflow or underflow, int_n goes low and stays low. At the same edge pol latches the sign of the charge unit: 1 for an overflow, 0 for an underflow. pol holds that value while int_n is low.
- R3: pol=0 means charge flowed out of the battery and pol=1 means charge flowed into it. While int_n is high and out_en=1, pol equals rev_chg as sampled at the previous rising edge.
- R4: clr_n passes through a two-flop synchronizer. If it is low at CLR_US*CYC_PER_US consecutive rising edges, int_n returns high two edges after the last of them. A low pulse one edge shorter is ignored. Each low pulse clears at most once.
- R5: The prescale counter keeps counting while int_n is latched low and while clr_n is low.
- R6: With auto_clr=1, a wrap drives int_n low for exactly HOLD_US*CYC_PER_US cycles. int_n then returns high without any action on clr_n.
- R7: shdn_n low (after its two-flop synchronizer) or uvlo high resets the counter, the latch and lost_unit. It also releases both outputs: out_en=0, int_n=1, pol=1.
- R8: After shutdown and undervoltage are both gone, out_en stays 0 and reversal events are ignored for INIT_US*CYC_PER_US cycles. Only then does counting begin.
- R9: A wrap that occurs while int_n is already low leaves pol unchanged and sets lost_unit. lost_unit stays set until the next shutdown or undervoltage reset.
- R10: If a qualified clear and a wrap fall on the same edge while int_n is latched, int_n stays low, pol takes the sign of the new unit, and lost_unit is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| shdn_n | input | 1 | Shutdown request, active low, asynchronous (synchronized inside) |
| uvlo | input | 1 | Undervoltage indication, active high, synchronous |
| auto_clr | input | 1 | 1 = the interrupt releases itself after the hold time |
| rev_evt | input | 1 | One-cycle pulse per integrator ramp reversal |
| rev_chg | input | 1 | Current direction: 1 = into the battery, 0 = out |
| clr_n | input | 1 | Interrupt clear, active low, asynchronous (synchronized inside) |
| int_n | output | 1 | Charge-unit interrupt, active low |
| pol | output | 1 | Polarity: 1 = into the battery, 0 = out |
| out_en | output | 1 | 0 = both outputs released (shutdown or settling) |
| lost_unit | output | 1 | Sticky flag: a charge unit arrived while the interrupt was latched |

## Verification
The delicate overlap is a qualified clear landing on the same edge as a new counter wrap. In that case the controller must both release and re-latch. The bench provokes this by holding clr_n low for exactly the qualifying length and placing one reversal on the release edge, with the counter sitting at zero. The run is judged correct if int_n stays low, pol flips to the new unit's sign and lost_unit stays clear. A second overlap is a wrap while the interrupt is already latched. It is judged by pol keeping its old sign while lost_unit rises.

// File: rtl/charge_unit_irq_pkg.sv
package charge_unit_irq_pkg;
    // Controller states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,   // shutdown or undervoltage held
        ST_INIT  = 3'd1,   // settling interval
        ST_IDLE  = 3'd2,   // counting, interrupt released
        ST_LATCH = 3'd3,   // interrupt low, waiting for qualified clear
        ST_HOLD  = 3'd4    // interrupt low for auto-clear minimum
    } cu_state_e;
endpackage

// File: rtl/cu_sync2.sv
module cu_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cu_low_qual.sv
// One-shot qualifier: hit pulses once when lo has been seen for QUAL_CYC cycles.
module cu_low_qual #(
    parameter int QUAL_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo,
    output logic hit
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);
    localparam logic [QW-1:0] FULL = QW'(QUAL_CYC);

    logic [QW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!lo)
            run_q <= '0;
        else if (run_q != FULL)
            run_q <= run_q + 1'b1;
    end

    assign hit = lo && (run_q == LAST);
endmodule

// File: rtl/cu_prescaler.sv
// Bidirectional prescaler; reports wraps combinationally for the edge that takes them.
module cu_prescaler #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         keep,   // 0 = return to zero at this edge
    input  logic         en,     // events are taken only when set
    input  logic         evt,
    input  logic         up,
    output logic         ovf,
    output logic         unf,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    assign ovf = en && evt && up  && (cnt == TOP);
    assign unf = en && evt && !up && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!keep)
            cnt <= '0;
        else if (en && evt)
            cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
    end
endmodule

// File: rtl/charge_unit_irq.sv
module charge_unit_irq
    import charge_unit_irq_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int CYC_PER_US = 50,
    parameter int CLR_US     = 20,
    parameter int HOLD_US    = 1,
    parameter int INIT_US    = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic uvlo,
    input  logic auto_clr,
    input  logic rev_evt,
    input  logic rev_chg,
    input  logic clr_n,
    output logic int_n,
    output logic pol,
    output logic out_en,
    output logic lost_unit
);
    localparam int CLR_CYC  = CLR_US * CYC_PER_US;
    localparam int HOLD_CYC = HOLD_US * CYC_PER_US;
    localparam int INIT_CYC = INIT_US * CYC_PER_US;   // assumed >= HOLD_CYC
    localparam int TW       = $clog2(INIT_CYC + 1);
    localparam logic [TW-1:0] INIT_LAST = TW'(INIT_CYC - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);

    cu_state_e  state, state_nxt;
    logic [1:0] sync_q;
    logic       shdn_s, clr_s, off_req, clr_ok;
    logic       run, run_nxt, ovf, unf, wrap;
    logic [CNT_W-1:0] cnt_q;
    logic [TW-1:0]    tmr_q;
    logic       pol_q, lost_q;

    cu_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_n, shdn_n}),
        .q     (sync_q)
    );
    assign shdn_s  = sync_q[0];
    assign clr_s   = sync_q[1];
    assign off_req = !shdn_s || uvlo;

    cu_low_qual #(.QUAL_CYC(CLR_CYC)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .lo    (!clr_s),
        .hit   (clr_ok)
    );

    assign run     = (state == ST_IDLE) || (state == ST_LATCH) || (state == ST_HOLD);
    assign run_nxt = (state_nxt == ST_IDLE) || (state_nxt == ST_LATCH) || (state_nxt == ST_HOLD);

    cu_prescaler #(.W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .keep  (run_nxt),
        .en    (run),
        .evt   (rev_evt),
        .up    (rev_chg),
        .ovf   (ovf),
        .unf   (unf),
        .cnt   (cnt_q)
    );
    assign wrap = ovf || unf;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (!off_req) state_nxt = ST_INIT;
            ST_INIT:  if (tmr_q == INIT_LAST) state_nxt = ST_IDLE;
            ST_IDLE:  if (wrap) state_nxt = auto_clr ? ST_HOLD : ST_LATCH;
            ST_LATCH: if (clr_ok && !wrap) state_nxt = ST_IDLE;
            ST_HOLD:  if (tmr_q == HOLD_LAST) state_nxt = ST_IDLE;
            default:  state_nxt = ST_OFF;
        endcase
        if (off_req) state_nxt = ST_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // Timer, polarity latch and missed-unit flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            pol_q  <= 1'b1;
            lost_q <= 1'b0;
        end else begin
            if ((state == ST_INIT || state == ST_HOLD) && state_nxt == state)
                tmr_q <= tmr_q + 1'b1;
            else
                tmr_q <= '0;

            if (off_req) begin
                pol_q  <= 1'b1;
                lost_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_OFF, ST_INIT: pol_q <= 1'b1;
                    ST_IDLE:         pol_q <= wrap ? ovf : rev_chg;
                    ST_LATCH: begin
                        if (clr_ok && wrap)      pol_q  <= ovf;
                        else if (clr_ok)         pol_q  <= rev_chg;
                        else if (wrap)           lost_q <= 1'b1;
                    end
                    ST_HOLD: begin
                        if (wrap)                lost_q <= 1'b1;
                        if (tmr_q == HOLD_LAST)  pol_q  <= rev_chg;
                    end
                    default:         pol_q <= 1'b1;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        out_en    = run;
        int_n     = !((state == ST_LATCH) || (state == ST_HOLD));
        pol       = run ? pol_q : 1'b1;
        lost_unit = lost_q;
    end
endmodule

// File: rtl/charge_unit_irq_chk.sv
module charge_unit_irq_chk
    import charge_unit_irq_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int HOLD_CYC = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_n,
    input logic             pol,
    input logic             out_en,
    input logic             lost_unit,
    input logic             clr_ok,
    input cu_state_e        state,
    input logic [CNT_W-1:0] cnt
);
    // R2: polarity frozen while latched unless a qualified clear intervened
    a_r2_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && $past(!int_n) && $past(out_en) && !$past(clr_ok)) |-> $stable(pol));

    // R7: released outputs and cleared flag whenever outputs are disabled
    a_r7_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (int_n && pol && !lost_unit));

    // R8: counter held at zero while not counting
    a_r8_cnt_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (cnt == '0));

    // R9: missed-unit flag is sticky until reset by shutdown
    a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lost_unit |=> (lost_unit || !out_en));

    // R4: a latched interrupt is released only after a qualified clear
    a_r4_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_n) && out_en && $past(state) == ST_LATCH) |-> $past(clr_ok));

    // R6: auto-clear keeps the interrupt low beyond its first cycle
    generate
        if (HOLD_CYC >= 2) begin : g_hold
            a_r6_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
                (state == ST_HOLD && $past(state) != ST_HOLD) |=> (!int_n || !out_en));
        end
    endgenerate
endmodule

bind charge_unit_irq charge_unit_irq_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_n     (int_n),
    .pol       (pol),
    .out_en    (out_en),
    .lost_unit (lost_unit),
    .clr_ok    (clr_ok),
    .state     (state),
    .cnt       (cnt_q)
);

// File: tb/charge_unit_irq_tb.sv
`timescale 1ns/1ps
module charge_unit_irq_tb;
    localparam int CNT_W      = 4;
    localparam int CYC_PER_US = 2;
    localparam int CLR_US     = 20;
    localparam int HOLD_US    = 1;
    localparam int INIT_US    = 5000;
    localparam int CLR_CYC    = CLR_US * CYC_PER_US;
    localparam int INIT_CYC   = INIT_US * CYC_PER_US;

    // row: [11:4] event count, [3] direction, [2] expected int_n, [1] expected pol, [0] clear after
    localparam int NROW = 9;
    localparam logic [11:0] VEC [NROW] = '{
        {8'd15, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd1,  1'b1, 1'b0, 1'b1, 1'b1},
        {8'd1,  1'b0, 1'b0, 1'b0, 1'b1},
        {8'd3,  1'b0, 1'b1, 1'b0, 1'b0},
        {8'd3,  1'b1, 1'b1, 1'b1, 1'b0},
        {8'd1,  1'b1, 1'b0, 1'b1, 1'b1},
        {8'd2,  1'b0, 1'b0, 1'b0, 1'b1},
        {8'd14, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd1,  1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, shdn_n = 1'b1, uvlo = 1'b0, auto_clr = 1'b0;
    logic rev_evt = 1'b0, rev_chg = 1'b1, clr_n = 1'b1;
    logic int_n, pol, out_en, lost_unit;
    int   n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    charge_unit_irq #(
        .CNT_W(CNT_W), .CYC_PER_US(CYC_PER_US), .CLR_US(CLR_US),
        .HOLD_US(HOLD_US), .INIT_US(INIT_US)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo), .auto_clr(auto_clr),
        .rev_evt(rev_evt), .rev_chg(rev_chg), .clr_n(clr_n),
        .int_n(int_n), .pol(pol), .out_en(out_en), .lost_unit(lost_unit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // called at a negedge; the event is taken at the next rising edge
    task automatic send_evt(input logic dir, input int n);
        for (int i = 0; i < n; i++) begin
            rev_evt = 1'b1;
            rev_chg = dir;
            @(negedge clk);
            rev_evt = 1'b0;
        end
    endtask

    task automatic pulse_clr(input int n);
        clr_n = 1'b0;
        repeat (n) @(negedge clk);
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset out_en", out_en, 1'b0);
        check("R7 reset int_n", int_n, 1'b1);
        check("R7 reset pol", pol, 1'b1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        send_evt(1'b1, 5);              // R8: ignored during settling
        check("R8 settling out_en", out_en, 1'b0);
        repeat (INIT_CYC) @(negedge clk);
        check("R8 counting out_en", out_en, 1'b1);

        // table of event runs
        for (int r = 0; r < NROW; r++) begin
            logic [11:0] v;
            v = VEC[r];
            send_evt(v[3], int'(v[11:4]));
            check(v[2] ? "R1 no wrap int_n" : "R2 wrap int_n", int_n, v[2]);
            check(v[2] ? "R3 realtime pol" : "R2 latched pol", pol, v[1]);
            if (v[0]) begin
                pulse_clr(CLR_CYC);
                check("R4 cleared int_n", int_n, 1'b1);
                check("R3 pol after clear", pol, v[3]);
            end
        end

        // R4: short clear ignored; R5: counting continues under latch and clear
        send_evt(1'b1, 1);
        check("R2 overflow int_n", int_n, 1'b0);
        pulse_clr(CLR_CYC - 1);
        check("R4 short clear ignored", int_n, 1'b0);
        clr_n = 1'b0;
        send_evt(1'b1, 15);
        repeat (CLR_CYC - 15) @(negedge clk);
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 full clear", int_n, 1'b1);
        check("R9 no loss yet", lost_unit, 1'b0);
        send_evt(1'b1, 1);
        check("R5 counted while latched", int_n, 1'b0);

        // R10: qualified clear and underflow on the same edge
        clr_n = 1'b0;
        repeat (CLR_CYC) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        send_evt(1'b0, 1);
        check("R10 int_n stays low", int_n, 1'b0);
        check("R10 pol new sign", pol, 1'b0);
        check("R10 no loss", lost_unit, 1'b0);
        pulse_clr(CLR_CYC);
        check("R10 later clear", int_n, 1'b1);

        // R9: wrap while latched
        send_evt(1'b0, 16);
        check("R2 underflow int_n", int_n, 1'b0);
        send_evt(1'b1, 1);
        check("R9 pol kept", pol, 1'b0);
        check("R9 lost set", lost_unit, 1'b1);
        pulse_clr(CLR_CYC);
        check("R9 lost sticky", lost_unit, 1'b1);
        check("R3 pol after clear", pol, 1'b1);

        // R7/R8: shutdown
        shdn_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 shdn out_en", out_en, 1'b0);
        check("R7 shdn pol", pol, 1'b1);
        check("R7 shdn lost", lost_unit, 1'b0);
        send_evt(1'b1, 3);
        shdn_n = 1'b1;
        repeat (INIT_CYC) @(negedge clk);
        check("R8 still settling", out_en, 1'b0);
        repeat (4) @(negedge clk);
        check("R8 settled", out_en, 1'b1);
        send_evt(1'b1, 15);
        check("R7 counter reset", int_n, 1'b1);
        send_evt(1'b1, 1);
        check("R1 overflow after reset", int_n, 1'b0);
        pulse_clr(CLR_CYC);

        // R7: undervoltage
        uvlo = 1'b1;
        @(negedge clk);
        uvlo = 1'b0;
        check("R7 uvlo out_en", out_en, 1'b0);
        check("R7 uvlo int_n", int_n, 1'b1);
        repeat (INIT_CYC + 4) @(negedge clk);
        check("R8 uvlo settled", out_en, 1'b1);

        // R6: auto-clear
        auto_clr = 1'b1;
        send_evt(1'b1, 16);
        check("R6 hold first", int_n, 1'b0);
        check("R6 hold pol", pol, 1'b1);
        @(negedge clk);
        check("R6 hold second", int_n, 1'b0);
        @(negedge clk);
        check("R6 auto release", int_n, 1'b1);
        auto_clr = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule